// File: doc/BRIEF.md
# Card Function Event and Mask Register Bank

This block holds the event and mask state for one card function. It latches
internal wake-up requests and internal interrupt or power-down requests into
sticky event bits, and software clears them by writing ones. The latched bits
drive two registered outputs. One is an active-low card interrupt line, gated
by a mask bit that software can write. The other is a system-change line for
power-management events. Its gate is two mask bits that software cannot write:
both copy the power-management enable input.

Software reaches four 32-bit words through a word-indexed port. Word 0 holds
the sticky events. Word 1 holds the masks. Word 2 shows the live request
inputs. Word 3 is a write-only port that forces event bits on. Reads are
combinational. Writes take effect at the clock edge. When the parameter
`BANK_EN` is 0, the bank reads as zero, ignores writes and keeps both outputs
inactive.

Top module: `fevt_bank`

## Requirements
- R1: After reset, all four words read 0 while the request inputs are low, `sys_chg` is 0 and `card_irq_n` is 1.
- R2: Only these bits can read as 1: bit 4 and bit 15 of words 0 and 2, and bits 4, 14 and 15 of word 1. Every other bit, including bits 3..0 in every word, reads 0. Word 3 always reads 0.
- R3: `wake_req` high at a clock edge sets word 0 bit 4. `irq_req` high at a clock edge sets word 0 bit 15. Each bit reads back as 1 from the next cycle on and stays set.
- R4: Writing word 0 with a 1 in bit 4 or bit 15 clears that event bit at that edge. A 0 in that bit position leaves the event bit unchanged.
- R5: A request input, or a force write, in the same cycle as a clearing write to the same bit leaves the bit set.
- R6: Word 1 bits 4 and 14 both read the value `pm_en` had at the previous clock edge. Both reset to 0. Writes to them have no effect.
- R7: Word 1 bit 15 is the interrupt mask. A write to word 1 loads it from write-data bit 15, it reads back, and it resets to 0.
- R8: `sys_chg` is 1 in a cycle exactly when, one edge earlier, word 0 bit 4 was set and word 1 bits 4 and 14 were both set. It drops in the cycle after the event bit is cleared.
- R9: `card_irq_n` is 0 in a cycle exactly when, one edge earlier, word 0 bit 15 and word 1 bit 15 were both set.
- R10: Word 2 shows the live `wake_req` in bit 4 and the live `irq_req` in bit 15. Writes to word 2 change no state.
- R11: Writing word 3 with a 1 in bit 4 or bit 15 sets the matching event bit in word 0. A 0 in a bit position has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word index: 0 events, 1 masks, 2 live inputs, 3 force |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data of the addressed word |
| wake_req | input | 1 | Internal wake-up request |
| irq_req | input | 1 | Internal interrupt or power-down request |
| pm_en | input | 1 | Power-management enable mirrored into mask bits 4 and 14 |
| sys_chg | output | 1 | Registered system-change (power event) output |
| card_irq_n | output | 1 | Registered active-low card interrupt |

## Verification
The hardest case is a clearing write that meets a new set in the same edge.
The set can come from a request input or from the force word. A second hard
case is the interaction of the mirrored mask bits with an event that is already
latched. A purely random stream rarely lines these up. Directed steps therefore
hold `wake_req` high during a word-0 clearing write. They also toggle `pm_en`
while a wake event is latched, and try to write the mirrored mask bits against
`pm_en`. A seeded random stream follows, with sparse events and writes to random
words and values, and each cycle is compared against a bench model.

// File: rtl/fevt_pkg.sv
package fevt_pkg;
  // Bit positions decoded by neighbours and software
  localparam int WAKE_BIT = 4;
  localparam int WKUP_BIT = 14;
  localparam int INTR_BIT = 15;

  // Word indices
  localparam int OFS_EVT = 0;
  localparam int OFS_MSK = 1;
  localparam int OFS_PRS = 2;
  localparam int OFS_FRC = 3;

  // Sticky bit with write-one-to-clear; a set in the same cycle wins.
  function automatic logic w1c_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Wake gate needs the event and both mask bits.
  function automatic logic wake_gate(logic evt, logic msk_lo, logic msk_hi);
    return evt & msk_lo & msk_hi;
  endfunction

  // Interrupt gate: event and mask.
  function automatic logic intr_gate(logic evt, logic msk);
    return evt & msk;
  endfunction
endpackage

// File: rtl/fevt_latch.sv
module fevt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import fevt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= w1c_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/fevt_out.sv
module fevt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt,
  input  logic wake_msk_lo,
  input  logic wake_msk_hi,
  input  logic irq_evt,
  input  logic irq_msk,
  output logic sys_chg_o,
  output logic irq_n_o
);
  import fevt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_chg_o <= 1'b0;
      irq_n_o   <= 1'b1;
    end else begin
      sys_chg_o <= wake_gate(wake_evt, wake_msk_lo, wake_msk_hi);
      irq_n_o   <= ~intr_gate(irq_evt, irq_msk);
    end
  end
endmodule

// File: rtl/fevt_rdmux.sv
module fevt_rdmux #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              evt_wake,
  input  logic              evt_irq,
  input  logic              msk_wake,
  input  logic              msk_wkup,
  input  logic              msk_irq,
  input  logic              live_wake,
  input  logic              live_irq,
  output logic [DATA_W-1:0] rdata
);
  import fevt_pkg::*;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_EVT)) begin
      rdata[WAKE_BIT] = evt_wake;
      rdata[INTR_BIT] = evt_irq;
    end else if (addr == ADDR_W'(OFS_MSK)) begin
      rdata[WAKE_BIT] = msk_wake;
      rdata[WKUP_BIT] = msk_wkup;
      rdata[INTR_BIT] = msk_irq;
    end else if (addr == ADDR_W'(OFS_PRS)) begin
      rdata[WAKE_BIT] = live_wake;
      rdata[INTR_BIT] = live_irq;
    end
  end
endmodule

// File: rtl/fevt_bank.sv
module fevt_bank #(
  parameter bit BANK_EN = 1'b1,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              wake_req,
  input  logic              irq_req,
  input  logic              pm_en,
  output logic              sys_chg,
  output logic              card_irq_n
);
  import fevt_pkg::*;

  localparam int NUM_EVT = 2;

  // Named internal events, visible to the bound checker
  logic wr_evt, wr_msk, wr_frc;
  logic evt_wake_q, evt_irq_q;
  logic pm_q, irq_msk_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  generate
    if (BANK_EN) begin : g_on
      logic [NUM_EVT-1:0] set_v, clr_v, q_v;
      int unsigned        bit_pos [NUM_EVT];

      assign bit_pos[0] = WAKE_BIT;
      assign bit_pos[1] = INTR_BIT;

      assign wr_evt = wr_en && (addr == ADDR_W'(OFS_EVT));
      assign wr_msk = wr_en && (addr == ADDR_W'(OFS_MSK));
      assign wr_frc = wr_en && (addr == ADDR_W'(OFS_FRC));

      assign set_v[0] = wake_req | (wr_frc & wdata[WAKE_BIT]);
      assign set_v[1] = irq_req  | (wr_frc & wdata[INTR_BIT]);

      for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        assign clr_v[i] = wr_evt & wdata[bit_pos[i]];
        fevt_latch u_latch (
          .clk   (clk),
          .rst_n (rst_n),
          .set_i (set_v[i]),
          .clr_i (clr_v[i]),
          .q_o   (q_v[i])
        );
      end

      assign evt_wake_q = q_v[0];
      assign evt_irq_q  = q_v[1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pm_q      <= 1'b0;
          irq_msk_q <= 1'b0;
        end else begin
          pm_q <= pm_en;
          if (wr_msk) irq_msk_q <= wdata[INTR_BIT];
        end
      end

      fevt_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_evt    (evt_wake_q),
        .wake_msk_lo (pm_q),
        .wake_msk_hi (pm_q),
        .irq_evt     (evt_irq_q),
        .irq_msk     (irq_msk_q),
        .sys_chg_o   (sys_chg),
        .irq_n_o     (card_irq_n)
      );

      fevt_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .addr      (addr),
        .evt_wake  (evt_wake_q),
        .evt_irq   (evt_irq_q),
        .msk_wake  (pm_q),
        .msk_wkup  (pm_q),
        .msk_irq   (irq_msk_q),
        .live_wake (wake_req),
        .live_irq  (irq_req),
        .rdata     (rdata)
      );
    end else begin : g_off
      assign wr_evt     = 1'b0;
      assign wr_msk     = 1'b0;
      assign wr_frc     = 1'b0;
      assign evt_wake_q = 1'b0;
      assign evt_irq_q  = 1'b0;
      assign pm_q       = 1'b0;
      assign irq_msk_q  = 1'b0;
      assign rdata      = '0;
      assign sys_chg    = 1'b0;
      assign card_irq_n = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/fevt_bank_chk.sv
module fevt_bank_chk #(
  parameter bit BANK_EN = 1'b1,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_evt,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              wake_req,
  input logic              irq_req,
  input logic              pm_en,
  input logic              evt_wake_q,
  input logic              evt_irq_q,
  input logic              pm_q,
  input logic              irq_msk_q,
  input logic              sys_chg,
  input logic              card_irq_n
);
  if (BANK_EN) begin : g_chk
    // R2: low nibble never reads 1
    assert_resv_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[3:0] == 4'b0);
    // R3
    assert_wake_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> evt_wake_q);
    assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> evt_irq_q);
    // R4: only a one in the bit clears it
    assert_wake_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_wake_q && !(wr_evt && wdata[4])) |=> evt_wake_q);
    // R4 and R5: a clear without a set empties the bit
    assert_wake_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && wdata[4] && !wake_req) |=> !evt_wake_q);
    // R6
    assert_pm_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pm_q == $past(pm_en)));
    // R8
    assert_sys_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_wake_q && pm_q) |=> sys_chg);
    assert_sys_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_wake_q && pm_q) |=> !sys_chg);
    // R9
    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_irq_q && irq_msk_q) |=> !card_irq_n);
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_irq_q && irq_msk_q) |=> card_irq_n);
  end

  logic unused_chk;
  assign unused_chk = ^{wdata, rdata, irq_req};
endmodule

bind fevt_bank fevt_bank_chk #(.BANK_EN(BANK_EN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fevt_bank_tb.sv
module fevt_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake_req = 1'b0, irq_req = 1'b0, pm_en = 1'b0;
  logic        sys_chg, card_irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench model of the requirements
  logic m_wake = 0, m_irq = 0, m_msk = 0, m_pm = 0, m_sys = 0, m_irqn = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fevt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wake_req(wake_req), .irq_req(irq_req), .pm_en(pm_en),
    .sys_chg(sys_chg), .card_irq_n(card_irq_n)
  );

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[4] = m_wake; v[15] = m_irq; end
      2'd1: begin v[4] = m_pm; v[14] = m_pm; v[15] = m_msk; end
      2'd2: begin v[4] = wake_req; v[15] = irq_req; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] allowed(logic [1:0] a);
    case (a)
      2'd0, 2'd2: return 32'h0000_8010;
      2'd1:       return 32'h0000_C010;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at the edge, check at next negedge
  task automatic cyc(logic w, logic [1:0] a, logic [31:0] d,
                     logic wk, logic ir, logic pm);
    logic clr_w, clr_i, frc_w, frc_i;
    wr_en = w; addr = a; wdata = d; wake_req = wk; irq_req = ir; pm_en = pm;
    @(posedge clk);
    m_sys  = m_wake & m_pm & m_pm;
    m_irqn = ~(m_irq & m_msk);
    clr_w = w && a == 2'd0 && d[4];
    clr_i = w && a == 2'd0 && d[15];
    frc_w = w && a == 2'd3 && d[4];
    frc_i = w && a == 2'd3 && d[15];
    m_wake = wk | frc_w | (m_wake & ~clr_w);
    m_irq  = ir | frc_i | (m_irq & ~clr_i);
    if (w && a == 2'd1) m_msk = d[15];
    m_pm = pm;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 sys_chg", {31'b0, sys_chg}, {31'b0, m_sys});
    chk("R9 card_irq_n", {31'b0, card_irq_n}, {31'b0, m_irqn});
  endtask

  task automatic rd(logic [1:0] a);
    string tag;
    case (a)
      2'd0: tag = "R3 event word";
      2'd1: tag = "R6 mask word";
      2'd2: tag = "R10 live word";
      default: tag = "R11 force word";
    endcase
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
    chk("R2 reserved bits", rdata & ~allowed(a), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 sys_chg reset", {31'b0, sys_chg}, 32'h0);
    chk("R1 card_irq_n reset", {31'b0, card_irq_n}, 32'h1);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 word reset", rdata, 32'h0);
    end

    // R3: wake latches; pm off keeps sys_chg low
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    addr = 0; #1; chk("R3 wake latched", rdata, 32'h0000_0010);
    // R6: pm_en mirrors; R8: sys_chg follows
    cyc(0, 0, 0, 0, 0, 1);
    addr = 1; #1; chk("R6 mask mirror", rdata, 32'h0000_4010);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 sys_chg high", {31'b0, sys_chg}, 32'h1);
    // R6: writing the mirrored bits has no effect; R7 loads mask bit 15
    cyc(1, 1, 32'h0000_8000, 0, 0, 1);
    addr = 1; #1; chk("R7 mask15 written", rdata, 32'h0000_C010);
    cyc(1, 1, 32'hFFFF_BFEF, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    addr = 1; #1; chk("R6 mirrored bits not writable", rdata, 32'h0000_8000);
    cyc(0, 0, 0, 0, 0, 1);
    // R4: writing 0 keeps the bit
    cyc(1, 0, 32'hFFFF_7FEF, 0, 0, 1);
    addr = 0; #1; chk("R4 write0 no effect", rdata, 32'h0000_0010);
    // R5: clear with simultaneous request keeps it
    cyc(1, 0, 32'h0000_0010, 1, 0, 1);
    addr = 0; #1; chk("R5 set wins", rdata, 32'h0000_0010);
    // R5: clear with simultaneous force is impossible on one port; clear now
    cyc(1, 0, 32'h0000_0010, 0, 0, 1);
    addr = 0; #1; chk("R4 w1c clear", rdata, 32'h0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 sys_chg drops after clear", {31'b0, sys_chg}, 32'h0);
    // R11: force both; R9 interrupt asserts
    cyc(1, 1, 32'h0000_8000, 0, 0, 1);
    cyc(1, 3, 32'h0000_8010, 0, 0, 1);
    addr = 0; #1; chk("R11 force sets", rdata, 32'h0000_8010);
    addr = 3; #1; chk("R11 force reads 0", rdata, 32'h0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R9 card_irq_n low", {31'b0, card_irq_n}, 32'h0);
    // R10: live view and ignored write
    cyc(1, 2, 32'hFFFF_FFFF, 0, 1, 1);
    addr = 2; #1; chk("R10 live irq", rdata, 32'h0000_8000);
    cyc(1, 0, 32'h0000_8010, 0, 0, 0);
    rd(0); rd(1); rd(2); rd(3);

    // Seeded random stream
    for (int n = 0; n < N_RAND; n++) begin
      logic w; logic [1:0] a; logic [31:0] d;
      w = ($urandom % 3) == 0;
      a = 2'($urandom);
      d = $urandom;
      cyc(w, a, d, ($urandom % 8) == 0, ($urandom % 9) == 0,
          ($urandom % 16) != 0 ? pm_en : ~pm_en);
      rd(2'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule